// File: doc/BRIEF.md
# Streaming Packet Checker with Header Compare

This block sits on a 64-bit valid/ready stream that carries a last-word marker. A packet is checked against a set of expected fields that are loaded before the packet arrives. The expected fields are the sequence number, the byte size, the stream identifier, three flag bits and an optional 64-bit timestamp. The checker compares the first word against a packed header built from those fields. When the has-time flag is set, it compares the second word against the timestamp. Every word after that is compared against a regenerated counting pattern of four 16-bit lanes.

The byte size covers the header and the optional time word. It sets how many words the packet must contain. In the final word, only the bytes that the size covers take part in the compare. Mismatches raise sticky flags in four classes: header, time, payload and framing. A one-cycle done pulse marks the end of each checked packet. A testbench or a monitoring block loads an expectation and lets the stream through. It reads the flags when done pulses and clears them with a dedicated input.

Top module: `stream_pkt_checker`

## Requirements
- R1: After reset, `s_ready`, `pkt_done` and all four error flags are low. An `exp_load` pulse while `s_ready` is low raises `s_ready` on the next cycle. `s_ready` then stays high, across cycles with `s_valid` low, until the packet's closing word is accepted. It falls in the cycle after that word.
- R2: The first word of a packet must equal, from bit 63 down to bit 0, {ext, 1'b0, has_time, eob, seq[11:0], size[15:0], sid[31:0]}. Any difference, including a one in bit 62, sets `err_hdr`.
- R3: When the expected has-time flag is 1, the second word must equal `exp_stamp`. Any difference sets `err_time`.
- R4: Payload word number p (counting from 0 after the header and the optional time word) must carry lane values n, n+1, n+2, n+3 with n = 4p modulo 2^16. Lane n sits in bits 63:48 and lane n+3 in bits 15:0. Any difference sets `err_pay`.
- R5: The expected word count is the larger of ceil(size/8) and 2 + has_time. So a packet always holds at least one payload word.
- R6: In the predicted final word, only the most significant (size mod 8) bytes are compared, or all 8 bytes when size mod 8 is 0. Differences in the other bytes have no effect on `err_pay`.
- R7: `err_frame` is set when `s_last` arrives on a word before the predicted final word, or when the predicted final word arrives without `s_last`. The packet ends on whichever of the two comes first.
- R8: Error flags stay set until `err_clear` is high at a clock edge. A mismatch detected in the same cycle as a clear leaves its flag set.
- R9: `pkt_done` is high for exactly one cycle, the cycle after the packet's closing word is accepted. In that cycle the error flags already include that word's result.
- R10: An `exp_load` pulse while `s_ready` is high is ignored. The packet in progress is still checked against the fields loaded before it, and `s_ready` still falls when that packet ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_load | input | 1 | Load the expected fields and arm the checker |
| exp_ext | input | 1 | Expected extension flag (header bit 63) |
| exp_eob | input | 1 | Expected end-of-burst flag (header bit 60) |
| exp_has_time | input | 1 | Expected has-time flag (header bit 61); also selects the time word |
| exp_seq | input | 12 | Expected sequence number |
| exp_size | input | 16 | Expected packet size in bytes, header and time word included |
| exp_sid | input | 32 | Expected stream identifier |
| exp_stamp | input | 64 | Expected timestamp |
| s_data | input | 64 | Stream data word |
| s_valid | input | 1 | Stream word valid |
| s_last | input | 1 | Stream last-word marker |
| s_ready | output | 1 | Checker accepts a word this cycle |
| err_clear | input | 1 | Clear all sticky error flags |
| err_hdr | output | 1 | Sticky header mismatch flag |
| err_time | output | 1 | Sticky timestamp mismatch flag |
| err_pay | output | 1 | Sticky payload mismatch flag |
| err_frame | output | 1 | Sticky framing error flag |
| pkt_done | output | 1 | One-cycle pulse after a packet ends |

## Verification
Two cases are hard to reach from the ports. The first is the byte mask of the final word: the only visible effect of a wrong mask is a flag that should or should not have risen. The bench therefore sends packets whose sizes leave a remainder, and flips bits on purpose either only in the uncovered low bytes or in a single covered byte. It also sends sizes below the minimum word count, where the floor of 2 + has_time decides the final word. The second is a reload during a packet. The bench pulses `exp_load` with different fields in the middle of a clean packet, then checks that no flag rises and that `s_ready` falls when the packet ends.

// File: rtl/pkc_pkg.sv
`timescale 1ns/1ps
package pkc_pkg;
  localparam int SEQ_W  = 12;
  localparam int SIZE_W = 16;
  localparam int SID_W  = 32;
  localparam int WORD_W = 64;
  localparam int LANE_W = 16;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int BYTES  = WORD_W / 8;
  localparam int FLAG_N = 4;

  typedef struct packed {
    logic              ext;
    logic              eob;
    logic              has_time;
    logic [SEQ_W-1:0]  seq;
    logic [SIZE_W-1:0] size;
    logic [SID_W-1:0]  sid;
    logic [WORD_W-1:0] stamp;
  } pkc_exp_t;

  // packed header image, trailer position forced to zero
  function automatic logic [WORD_W-1:0] pkc_header(input pkc_exp_t e);
    return {e.ext, 1'b0, e.has_time, e.eob, e.seq, e.size, e.sid};
  endfunction

  // words a packet must hold: ceil(size/8), at least header+time+one payload
  function automatic logic [SIZE_W-1:0] pkc_words(input logic [SIZE_W-1:0] size,
                                                  input logic ht);
    logic [SIZE_W:0]   ceil_w;
    logic [SIZE_W-1:0] floor_w;
    ceil_w  = ({1'b0, size} + (SIZE_W+1)'(7)) >> 3;
    floor_w = SIZE_W'(2) + SIZE_W'(ht);
    return (ceil_w[SIZE_W-1:0] < floor_w) ? floor_w : ceil_w[SIZE_W-1:0];
  endfunction

  // counting pattern for payload word p
  function automatic logic [WORD_W-1:0] pkc_lanes(input logic [SIZE_W-1:0] p);
    logic [LANE_W-1:0] base;
    logic [WORD_W-1:0] w;
    base = LANE_W'(p << 2);
    w    = '0;
    for (int k = 0; k < LANES; k++)
      w[WORD_W-1-k*LANE_W -: LANE_W] = base + LANE_W'(k);
    return w;
  endfunction

  // bytes compared in the final word, bit b = byte b (byte 7 is MSB)
  function automatic logic [BYTES-1:0] pkc_byte_mask(input logic [2:0] rem);
    logic [BYTES-1:0] ones;
    ones = '1;
    return (rem == 3'd0) ? ones : ~(ones >> rem);
  endfunction
endpackage

// File: rtl/pkc_plan.sv
`timescale 1ns/1ps
module pkc_plan
  import pkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exp_load,
  input  pkc_exp_t          exp_in,
  input  logic              take,
  input  logic              end_take,
  output logic              armed,
  output logic              arm_event,
  output pkc_exp_t          exp_q,
  output logic [SIZE_W-1:0] total_q,
  output logic [SIZE_W-1:0] idx_q
);
  assign arm_event = exp_load & ~armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed   <= 1'b0;
      exp_q   <= '0;
      total_q <= '0;
      idx_q   <= '0;
    end else if (arm_event) begin
      armed   <= 1'b1;
      exp_q   <= exp_in;
      total_q <= pkc_words(exp_in.size, exp_in.has_time);
      idx_q   <= '0;
    end else if (take) begin
      idx_q <= idx_q + SIZE_W'(1);
      if (end_take) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/pkc_word_cmp.sv
`timescale 1ns/1ps
module pkc_word_cmp
  import pkc_pkg::*;
(
  input  pkc_exp_t          exp_q,
  input  logic [SIZE_W-1:0] total_q,
  input  logic [SIZE_W-1:0] idx_q,
  input  logic [WORD_W-1:0] data,
  input  logic              last,
  output logic              is_final,
  output logic              hdr_bad,
  output logic              time_bad,
  output logic              pay_bad,
  output logic              frame_bad
);
  logic              slot_hdr, slot_time;
  logic [SIZE_W-1:0] pidx;
  logic [WORD_W-1:0] ref_word;
  logic [BYTES-1:0]  bmask;
  logic [WORD_W-1:0] bit_mask;
  logic              differs;

  assign is_final  = (idx_q == total_q - SIZE_W'(1));
  assign slot_hdr  = (idx_q == '0);
  assign slot_time = exp_q.has_time && (idx_q == SIZE_W'(1));
  assign pidx      = idx_q - SIZE_W'(1) - SIZE_W'(exp_q.has_time);
  assign bmask     = pkc_byte_mask(exp_q.size[2:0]);

  always_comb begin
    if (slot_hdr)       ref_word = pkc_header(exp_q);
    else if (slot_time) ref_word = exp_q.stamp;
    else                ref_word = pkc_lanes(pidx);
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign bit_mask[b*8 +: 8] = {8{~is_final | bmask[b]}};
  end

  assign differs   = |((data ^ ref_word) & bit_mask);
  assign hdr_bad   = slot_hdr & differs;
  assign time_bad  = slot_time & differs;
  assign pay_bad   = ~slot_hdr & ~slot_time & differs;
  assign frame_bad = last ^ is_final;
endmodule

// File: rtl/pkc_flags.sv
`timescale 1ns/1ps
module pkc_flags
  import pkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic              end_take,
  input  logic [FLAG_N-1:0] ev,
  output logic [FLAG_N-1:0] flags,
  output logic              done
);
  logic [FLAG_N-1:0] hits;
  assign hits = take ? ev : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      done  <= 1'b0;
    end else begin
      flags <= (clear ? '0 : flags) | hits;
      done  <= end_take;
    end
  end
endmodule

// File: rtl/stream_pkt_checker.sv
`timescale 1ns/1ps
module stream_pkt_checker
  import pkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exp_load,
  input  logic              exp_ext,
  input  logic              exp_eob,
  input  logic              exp_has_time,
  input  logic [SEQ_W-1:0]  exp_seq,
  input  logic [SIZE_W-1:0] exp_size,
  input  logic [SID_W-1:0]  exp_sid,
  input  logic [WORD_W-1:0] exp_stamp,
  input  logic [WORD_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              err_clear,
  output logic              err_hdr,
  output logic              err_time,
  output logic              err_pay,
  output logic              err_frame,
  output logic              pkt_done
);
  pkc_exp_t          exp_in, exp_q;
  logic              armed, arm_event;
  logic [SIZE_W-1:0] total_q, idx_q;
  logic              take, end_take, is_final;
  logic              ev_hdr, ev_time, ev_pay, ev_frame;
  logic [FLAG_N-1:0] flags;

  assign exp_in = '{ext: exp_ext, eob: exp_eob, has_time: exp_has_time,
                    seq: exp_seq, size: exp_size, sid: exp_sid, stamp: exp_stamp};

  assign s_ready  = armed;
  assign take     = s_valid & armed;
  assign end_take = take & (s_last | is_final);

  pkc_plan u_plan (
    .clk(clk), .rst_n(rst_n), .exp_load(exp_load), .exp_in(exp_in),
    .take(take), .end_take(end_take), .armed(armed), .arm_event(arm_event),
    .exp_q(exp_q), .total_q(total_q), .idx_q(idx_q)
  );

  pkc_word_cmp u_cmp (
    .exp_q(exp_q), .total_q(total_q), .idx_q(idx_q), .data(s_data),
    .last(s_last), .is_final(is_final), .hdr_bad(ev_hdr), .time_bad(ev_time),
    .pay_bad(ev_pay), .frame_bad(ev_frame)
  );

  pkc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clear(err_clear), .take(take),
    .end_take(end_take), .ev({ev_hdr, ev_time, ev_pay, ev_frame}),
    .flags(flags), .done(pkt_done)
  );

  assign {err_hdr, err_time, err_pay, err_frame} = flags;
endmodule

// File: rtl/stream_pkt_checker_sva.sv
`timescale 1ns/1ps
module stream_pkt_checker_sva (
  input logic clk,
  input logic rst_n,
  input logic exp_load,
  input logic s_ready,
  input logic err_clear,
  input logic err_hdr,
  input logic err_time,
  input logic err_pay,
  input logic err_frame,
  input logic pkt_done,
  input logic take,
  input logic end_take,
  input logic ev_hdr,
  input logic ev_frame
);
  a_r1_arm_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_load && !s_ready) |=> s_ready);
  a_r1_hold_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !end_take) |=> s_ready);
  a_r1_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_ready && !exp_load) |=> !s_ready);
  a_r10_end_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    end_take |=> !s_ready);
  a_r9_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    end_take |=> pkt_done);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);
  a_r9_no_stray_done: assert property (@(posedge clk) disable iff (!rst_n)
    !end_take |=> !pkt_done);
  a_r8_sticky_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hdr && !err_clear) |=> err_hdr);
  a_r8_sticky_time: assert property (@(posedge clk) disable iff (!rst_n)
    (err_time && !err_clear) |=> err_time);
  a_r8_sticky_pay: assert property (@(posedge clk) disable iff (!rst_n)
    (err_pay && !err_clear) |=> err_pay);
  a_r8_sticky_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !err_clear) |=> err_frame);
  a_r8_clear_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clear && !(take && ev_hdr)) |=> !err_hdr);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ev_hdr) |=> err_hdr);
  a_r7_frame_set: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ev_frame) |=> err_frame);
endmodule

bind stream_pkt_checker stream_pkt_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .exp_load(exp_load), .s_ready(s_ready),
  .err_clear(err_clear), .err_hdr(err_hdr), .err_time(err_time),
  .err_pay(err_pay), .err_frame(err_frame), .pkt_done(pkt_done),
  .take(take), .end_take(end_take), .ev_hdr(ev_hdr), .ev_frame(ev_frame)
);

// File: tb/stream_pkt_checker_bench.sv
`timescale 1ns/1ps
module stream_pkt_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exp_load = 1'b0, exp_ext = 1'b0, exp_eob = 1'b0, exp_has_time = 1'b0;
  logic [11:0] exp_seq = '0;
  logic [15:0] exp_size = '0;
  logic [31:0] exp_sid = '0;
  logic [63:0] exp_stamp = '0;
  logic [63:0] s_data = '0;
  logic        s_valid = 1'b0, s_last = 1'b0, err_clear = 1'b0;
  logic        s_ready, err_hdr, err_time, err_pay, err_frame, pkt_done;

  int n_checks = 0;
  int n_fail = 0;
  int done_cnt = 0;
  logic [3:0] sb_q[$];
  logic prev_done = 1'b0;

  always #2 clk = ~clk;

  stream_pkt_checker u_stream_pkt_checker (
    .clk(clk), .rst_n(rst_n), .exp_load(exp_load), .exp_ext(exp_ext),
    .exp_eob(exp_eob), .exp_has_time(exp_has_time), .exp_seq(exp_seq),
    .exp_size(exp_size), .exp_sid(exp_sid), .exp_stamp(exp_stamp),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .err_clear(err_clear), .err_hdr(err_hdr), .err_time(err_time),
    .err_pay(err_pay), .err_frame(err_frame), .pkt_done(pkt_done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // monitor: pop the expected flag set when a packet closes
  always @(negedge clk) begin
    if (rst_n) begin
      if (pkt_done && prev_done) check("R9 single-cycle done", 1, 0);
      if (pkt_done) begin
        if (sb_q.size() == 0) check("R9 unexpected done", 1, 0);
        else check("R2/R3/R4/R7 flags {hdr,time,pay,frame}",
                   {err_hdr, err_time, err_pay, err_frame}, sb_q.pop_front());
        done_cnt++;
      end
    end
    prev_done = pkt_done;
  end

  function automatic logic [63:0] hdr_img(input logic ext, ht, eob, input logic [11:0] seq,
                                          input logic [15:0] size, input logic [31:0] sid);
    return (64'(ext) << 63) | (64'(ht) << 61) | (64'(eob) << 60) |
           (64'(seq) << 48) | (64'(size) << 32) | 64'(sid);
  endfunction

  function automatic logic [63:0] pay_img(input int j);
    logic [15:0] n;
    n = 16'(4 * j);
    return {n, n + 16'd1, n + 16'd2, n + 16'd3};
  endfunction

  // driver: load expectation, stream words, push expected flags to scoreboard
  task automatic run_pkt(input logic ext, eob, ht, input logic [11:0] seq,
                         input logic [15:0] size, input logic [31:0] sid,
                         input logic [63:0] stamp, input int n_send, input int last_at,
                         input int bad_idx, input logic [63:0] bad_xor,
                         input bit gaps, input bit mid_load, input logic [3:0] expf);
    int target;
    @(negedge clk);
    exp_ext = ext; exp_eob = eob; exp_has_time = ht; exp_seq = seq;
    exp_size = size; exp_sid = sid; exp_stamp = stamp; exp_load = 1'b1;
    @(negedge clk);
    exp_load = 1'b0;
    check("R1 ready after load", s_ready, 1);
    sb_q.push_back(expf);
    target = done_cnt + 1;
    for (int i = 0; i < n_send; i++) begin
      logic [63:0] w;
      if (i == 0) w = hdr_img(ext, ht, eob, seq, size, sid);
      else if (ht && i == 1) w = stamp;
      else w = pay_img(i - 1 - int'(ht));
      if (i == bad_idx) w = w ^ bad_xor;
      s_data = w; s_valid = 1'b1; s_last = (i == last_at);
      if (mid_load && i == 1) begin
        exp_seq = seq + 12'd7; exp_sid = ~sid; exp_load = 1'b1;
      end
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      exp_load = 1'b0;
      s_valid = 1'b0; s_last = 1'b0; s_data = '0;
      if (gaps && i + 1 < n_send) begin
        @(negedge clk);
        check("R1 ready held over gap", s_ready, 1);
      end
    end
    for (int k = 0; k < 20 && done_cnt < target; k++) @(negedge clk);
    check("R9 done seen", done_cnt >= target, 1);
    repeat (3) @(negedge clk);
    check("R8 flags sticky", {err_hdr, err_time, err_pay, err_frame}, expf);
    check("R1/R10 ready low after packet", s_ready, 0);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check("R8 flags cleared", {err_hdr, err_time, err_pay, err_frame}, 0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 reset ready", s_ready, 0);
    check("R1 reset flags", {err_hdr, err_time, err_pay, err_frame, pkt_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 clean, no time, 4 words, with gaps
    run_pkt(0, 0, 0, 12'h005, 16'd32, 32'hA1B2C3D4, '0, 4, 3, -1, '0, 1, 0, 4'b0000);
    // R6 low (uncovered) bytes of final word corrupted: size 36 -> top 4 bytes
    run_pkt(0, 1, 1, 12'h010, 16'd36, 32'h00001234, 64'h0123456789ABCDEF,
            5, 4, 4, 64'h00000000_FFFFFFFF, 1, 0, 4'b0000);
    // R6 covered byte of final word corrupted
    run_pkt(0, 1, 1, 12'h011, 16'd36, 32'h00001234, 64'h0123456789ABCDEF,
            5, 4, 4, 64'h00000001_00000000, 0, 0, 4'b0010);
    // R2 sequence bit wrong
    run_pkt(1, 0, 0, 12'h0FF, 16'd24, 32'hDEADBEEF, '0, 3, 2, 0, 64'd1 << 48, 0, 0, 4'b1000);
    // R2 trailer position set
    run_pkt(0, 0, 0, 12'h100, 16'd24, 32'h11112222, '0, 3, 2, 0, 64'd1 << 62, 0, 0, 4'b1000);
    // R3 timestamp wrong
    run_pkt(0, 0, 1, 12'h200, 16'd24, 32'h5, 64'hFEEDFACECAFEF00D, 3, 2, 1, 64'd1, 0, 0, 4'b0100);
    // R4 middle payload word wrong
    run_pkt(0, 0, 0, 12'h300, 16'd40, 32'h6, '0, 5, 4, 2, 64'd1 << 20, 1, 0, 4'b0010);
    // R7 early last
    run_pkt(0, 0, 0, 12'h301, 16'd40, 32'h7, '0, 3, 2, -1, '0, 0, 0, 4'b0001);
    // R7 missing last on predicted final word
    run_pkt(0, 0, 0, 12'h302, 16'd24, 32'h8, '0, 3, -1, -1, '0, 0, 0, 4'b0001);
    // R5 size below minimum with time: 3 words
    run_pkt(0, 0, 1, 12'h303, 16'd8, 32'h9, 64'h42, 3, 2, -1, '0, 0, 0, 4'b0000);
    // R5/R6 size 9: 2 words, only top byte of final word covered
    run_pkt(0, 0, 0, 12'h304, 16'd9, 32'hA, '0, 2, 1, 1, 64'h00FFFFFF_FFFFFFFF, 0, 0, 4'b0000);
    // R5 size 17: 3 words, final word top byte corrupted
    run_pkt(0, 0, 0, 12'h305, 16'd17, 32'hB, '0, 3, 2, 2, 64'h80000000_00000000, 0, 0, 4'b0010);
    // R10 reload during a clean packet is ignored
    run_pkt(1, 1, 0, 12'h400, 16'd32, 32'hC0DE0001, '0, 4, 3, -1, '0, 0, 1, 4'b0000);
    // R2 both flags set, clean
    run_pkt(1, 1, 1, 12'hFFF, 16'd64, 32'hFFFFFFFF, 64'h1, 8, 7, -1, '0, 1, 0, 4'b0000);
    check("R9 scoreboard drained", sb_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule